// File: doc/BRIEF.md
# Complementary PWM with Dead Time

This block drives a pair of pulse-width-modulated outputs, A and B, from one free-running cycle counter clocked by the system clock. Output A is active from the start of each cycle for the duty interval. Output B takes the remainder of the cycle, but it is held off for a programmable gap after A drops and drops the same gap before the cycle ends. This keeps the two outputs from being on at once, which makes the pair suitable for half-bridge and similar complementary drive stages.

Period and duty are applied through working copies of the programmed values. In immediate mode, new values replace the working copies only when the cycle in progress ends. In glide mode, the working copies move one clock toward the programmed targets at the end of a cycle, and then wait a programmable number of whole cycles before the next move. The period input is coded as the cycle length minus two. Each output has its own polarity, and an enable and an idle-force control both park the outputs at their inactive levels.

Top module: `cpwm_dt`

## Requirements
- R1: While `rst` is high at a rising edge, the cycle counter clears to 0 and the working period and duty load directly from `period_m2` and `duty`. The first cycle after reset therefore starts at count 0 with those values.
- R2: One PWM cycle lasts the working period plus 2 clocks. The counter runs 0 up to working period + 1 and then returns to 0.
- R3: Output A is active while the count is less than the working duty.
- R4: Output B is active while the count is at least working duty + `gap` and count + `gap` is less than working period + 2.
- R5: Output A's active level is `pol_a` and output B's active level is `pol_b`: 1 means active high and 0 means active low. The inactive level is the complement.
- R6: While `hold_idle` is 1, both outputs sit at their inactive levels (`~pol_a`, `~pol_b`), regardless of the count.
- R7: While `enable` is 0, both outputs sit at their inactive levels.
- R8: With `glide` = 0, changes to `period_m2` or `duty` take effect only at the first clock of the next cycle. The cycle in progress keeps its old values.
- R9: With `glide` = 1, at the end of a cycle the working period and duty each move by one toward their targets, and only when `step_dly` cycles have been skipped since the last move. A `step_dly` of 0 moves them at every cycle end.
- R10: A working duty of at least the cycle length keeps A active for the whole cycle and B inactive.
- R11: A and B are never both at their active levels in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | 1 lets the outputs toggle, 0 parks them inactive |
| hold_idle | input | 1 | 1 forces both outputs to their inactive levels |
| glide | input | 1 | 0 applies new values at the cycle end, 1 steps toward them |
| pol_a | input | 1 | Active level of output A |
| pol_b | input | 1 | Active level of output B |
| period_m2 | input | 16 | Cycle length minus two, in clocks |
| duty | input | 16 | Active interval of A, in clocks |
| gap | input | 16 | Non-overlap interval, in clocks |
| step_dly | input | 8 | Cycles skipped between glide steps |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The outputs are combinational decodes of the registered count and working values. A change on `enable`, `hold_idle`, the polarity bits or `gap` therefore shows in the same clock, while a change in period or duty shows no earlier than the first clock of the next cycle. The bench keeps its own cycle model, which it advances at each rising edge using the inputs as they stood before that edge. Driver changes are placed two nanoseconds after the edge, and the outputs are compared at the falling edge, halfway between two edges. Every clock is compared, so any misplaced edge of A or B, and any glide step taken in the wrong cycle, shows up in that same clock.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int CW = 16;   // width of period, duty and gap values
    localparam int SW = 8;    // width of the glide step delay

    typedef enum logic {
        MODE_NOW   = 1'b0,
        MODE_GLIDE = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic [CW-1:0] per;
        logic [CW-1:0] duty;
    } work_t;

    // one unit toward the target, or no change once reached
    function automatic logic [CW-1:0] step_toward(input logic [CW-1:0] cur,
                                                  input logic [CW-1:0] tgt);
        if (cur < tgt)      return cur + CW'(1);
        else if (cur > tgt) return cur - CW'(1);
        else                return cur;
    endfunction

    function automatic logic drive_level(input logic active, input logic pol);
        return active ? pol : ~pol;
    endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] per_m2,
    output logic [CW:0]   cnt,
    output logic          eoc
);
    localparam logic [CW:0] ONE = (CW+1)'(1);

    logic [CW:0] last;

    assign last = {1'b0, per_m2} + ONE;
    assign eoc  = (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (eoc) cnt <= '0;
        else          cnt <= cnt + ONE;
    end

    // R2: the cycle closes by returning to zero
    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        eoc |=> (cnt == '0));

    // R2: inside a cycle the count advances by one per clock
    assert_count_R2: assert property (@(posedge clk) disable iff (rst)
        !eoc |=> (cnt == $past(cnt) + ONE));

endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow
    import cpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          eoc,
    input  upd_mode_e     mode,
    input  work_t         target,
    input  logic [SW-1:0] step_dly,
    output work_t         work
);
    logic [SW-1:0] skipped;

    always_ff @(posedge clk) begin
        if (rst) begin
            work    <= target;
            skipped <= '0;
        end else if (eoc) begin
            if (mode == MODE_NOW) begin
                work    <= target;
                skipped <= '0;
            end else if (skipped >= step_dly) begin
                work.per  <= step_toward(work.per, target.per);
                work.duty <= step_toward(work.duty, target.duty);
                skipped   <= '0;
            end else begin
                skipped <= skipped + SW'(1);
            end
        end
    end

    // R8: working values never change inside a cycle
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !eoc |=> ($stable(work.per) && $stable(work.duty)));

    // R9: a glide update moves each working value by at most one
    assert_step_R9: assert property (@(posedge clk) disable iff (rst)
        (eoc && mode == MODE_GLIDE) |=>
            ((work.per == $past(work.per)) ||
             (work.per == $past(work.per) + CW'(1)) ||
             (work.per + CW'(1) == $past(work.per))));

endmodule

// File: rtl/cpwm_outstage.sv
module cpwm_outstage
    import cpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW:0]   cnt,
    input  work_t         work,
    input  logic [CW-1:0] gap,
    input  logic          enable,
    input  logic          hold_idle,
    input  logic          pol_a,
    input  logic          pol_b,
    output logic          pwm_a,
    output logic          pwm_b
);
    localparam int EW = CW + 2;

    logic [EW-1:0] c_x, p_x, d_x, g_x;
    logic          a_on, b_on, live;

    always_comb begin
        c_x  = EW'(cnt);
        p_x  = EW'(work.per) + EW'(2);
        d_x  = EW'(work.duty);
        g_x  = EW'(gap);
        a_on = (c_x < d_x);
        b_on = (c_x >= d_x + g_x) && (c_x + g_x < p_x);
        live = enable && !hold_idle;
        pwm_a = drive_level(live && a_on, pol_a);
        pwm_b = drive_level(live && b_on, pol_b);
    end

    // R11: never both active
    assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !((pwm_a == pol_a) && (pwm_b == pol_b)));

    // R6/R7: parked outputs sit at the inactive level
    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (hold_idle || !enable) |-> ((pwm_a != pol_a) && (pwm_b != pol_b)));

endmodule

// File: rtl/cpwm_dt.sv
module cpwm_dt
    import cpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          hold_idle,
    input  logic          glide,
    input  logic          pol_a,
    input  logic          pol_b,
    input  logic [15:0]   period_m2,
    input  logic [15:0]   duty,
    input  logic [15:0]   gap,
    input  logic [7:0]    step_dly,
    output logic          pwm_a,
    output logic          pwm_b
);
    logic [CW:0] cnt;
    logic        eoc;
    work_t       target, work;
    upd_mode_e   mode;

    assign target.per  = period_m2;
    assign target.duty = duty;
    assign mode        = glide ? MODE_GLIDE : MODE_NOW;

    cpwm_timebase u_time (
        .clk    (clk),
        .rst    (rst),
        .per_m2 (work.per),
        .cnt    (cnt),
        .eoc    (eoc)
    );

    cpwm_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .eoc      (eoc),
        .mode     (mode),
        .target   (target),
        .step_dly (step_dly),
        .work     (work)
    );

    cpwm_outstage u_out (
        .clk       (clk),
        .rst       (rst),
        .cnt       (cnt),
        .work      (work),
        .gap       (gap),
        .enable    (enable),
        .hold_idle (hold_idle),
        .pol_a     (pol_a),
        .pol_b     (pol_b),
        .pwm_a     (pwm_a),
        .pwm_b     (pwm_b)
    );

endmodule

// File: tb/test_cpwm_dt.sv
module test_cpwm_dt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0, hold_idle = 1'b0, glide = 1'b0;
    logic        pol_a = 1'b1, pol_b = 1'b1;
    logic [15:0] period_m2 = 16'd6, duty = 16'd3, gap = 16'd0;
    logic [7:0]  step_dly = 8'd0;
    logic        pwm_a, pwm_b;

    cpwm_dt i_cpwm_dt (
        .clk(clk), .rst(rst), .enable(enable), .hold_idle(hold_idle),
        .glide(glide), .pol_a(pol_a), .pol_b(pol_b), .period_m2(period_m2),
        .duty(duty), .gap(gap), .step_dly(step_dly),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct { int cnt; int wp; int wd; } snap_t;
    snap_t sbq[$];

    int    total = 0, bad = 0, cycles = 0;
    string phase = "R1";
    bit    done = 1'b0;

    int m_cnt = 0, m_wp = 0, m_wd = 0, m_sk = 0;

    function automatic int toward(int cur, int tgt);
        if (cur < tgt) return cur + 1;
        if (cur > tgt) return cur - 1;
        return cur;
    endfunction

    // reference model: advances at each rising edge, pushes the state it predicts
    always @(posedge clk) begin
        snap_t s;
        if (rst) begin
            m_cnt = 0; m_wp = int'(period_m2); m_wd = int'(duty); m_sk = 0;
        end else if (m_cnt >= m_wp + 1) begin
            m_cnt = 0;
            if (!glide) begin
                m_wp = int'(period_m2); m_wd = int'(duty); m_sk = 0;
            end else if (m_sk >= int'(step_dly)) begin
                m_wp = toward(m_wp, int'(period_m2));
                m_wd = toward(m_wd, int'(duty));
                m_sk = 0;
            end else begin
                m_sk = m_sk + 1;
            end
        end else begin
            m_cnt = m_cnt + 1;
        end
        s.cnt = m_cnt; s.wp = m_wp; s.wd = m_wd;
        sbq.push_back(s);
    end

    // monitor: pops the prediction and compares halfway through the clock
    always @(negedge clk) begin
        if (!done && sbq.size() > 0) begin
            snap_t s;
            logic  ea, eb, an, bn, live;
            s    = sbq.pop_front();
            live = enable && !hold_idle;
            an   = s.cnt < s.wd;
            bn   = (s.cnt >= s.wd + int'(gap)) && (s.cnt + int'(gap) < s.wp + 2);
            ea   = (live && an) ? pol_a : ~pol_a;
            eb   = (live && bn) ? pol_b : ~pol_b;
            total++;
            if (pwm_a !== ea || pwm_b !== eb) begin
                bad++;
                $display("FAIL %s cnt=%0d a=%b b=%b expected a=%b b=%b",
                         phase, s.cnt, pwm_a, pwm_b, ea, eb);
            end
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    initial begin : watchdog
        while (cycles < 200000 && !done) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        phase = "R1";                    // reset state, outputs parked
        run(4);
        rst = 1'b0;
        run(6);

        phase = "R2"; enable = 1'b1;     // 8-clock cycle, gap 0
        run(40);

        phase = "R3"; duty = 16'd5; gap = 16'd1;
        run(30);

        phase = "R4"; period_m2 = 16'd10; duty = 16'd4; gap = 16'd2;
        run(50);

        phase = "R8"; run(3);            // change inside a cycle
        period_m2 = 16'd12; duty = 16'd2; gap = 16'd3;
        run(45);

        phase = "R5"; pol_a = 1'b0; pol_b = 1'b1;
        run(30);
        pol_a = 1'b1; pol_b = 1'b0;
        run(30);
        pol_b = 1'b1;

        phase = "R6"; hold_idle = 1'b1;
        run(20);
        hold_idle = 1'b0;

        phase = "R7"; enable = 1'b0;
        run(20);
        enable = 1'b1;

        phase = "R10"; period_m2 = 16'd6; duty = 16'd20; gap = 16'd1;
        run(40);

        phase = "R11"; duty = 16'd0; gap = 16'd0;
        run(30);

        phase = "R9"; period_m2 = 16'd8; duty = 16'd3; gap = 16'd1;
        run(30);
        glide = 1'b1; step_dly = 8'd2;
        period_m2 = 16'd13; duty = 16'd8;
        run(400);
        step_dly = 8'd0; period_m2 = 16'd4; duty = 16'd1;
        run(200);
        glide = 1'b0;
        run(20);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule